// File: doc/BRIEF.md
# Serial Character Frame Timer

This block measures out the duration of one asynchronous or synchronous serial character so that a separate shifter knows when a character has finished. It does not move any data bits. For each direction it works out how many half-bit periods one character lasts, using the current framing configuration. It then counts level changes of an external serial clock and emits a single-cycle done pulse when that many half-bits have passed. Counting in half-bits makes a frame with one and a half stop bits exact. Because both rising and falling edges of the external clock are counted, one half-bit equals one clock level change when no multiplier is selected.

The transmit and receive directions are separate channels. They share the parity, stop-bit and clock-multiplier settings, and each has its own character-length field, start request, cancel strobe, clock input and done output. In one transmit length mode, the number of data bits is taken from the leading pattern of the byte about to be sent. This lets a character carry between one and five data bits.

Top module: `char_frame_timer`

## Requirements
- R1: With parity enabled, 2 half-bits are added to the frame length. With parity disabled, nothing is added.
- R2: The receive length code adds 10 half-bits for code 0, 14 for code 1, 12 for code 2 and 16 for code 3.
- R3: The transmit length code adds 14 half-bits for code 1, 12 for code 2 and 16 for code 3.
- R4: For transmit length code 0, the value added is twice a data-bit count taken from the byte input. The count is 1 for pattern 1111000x, 2 for 1110000x, 3 for 110000xx and 4 for 10000xxx. Every other byte, including 000xxxxx, gives 5.
- R5: The stop code adds 0 half-bits for code 0 (synchronous), 4 for code 1, 5 for code 2 and 6 for code 3.
- R6: The multiplier code multiplies the half-bit sum by 1 for code 0, 16 for code 1, 32 for code 2 and 64 for code 3.
- R7: After a start, each level change of a channel's clock input uses up one count. The channel's done output goes high for exactly one cycle after the level change that uses up the last count. The other channel is unaffected.
- R8: A start loads the frame length only when the channel is idle, meaning its remaining count is zero. A start during a character is ignored, and clock level changes while idle produce no done pulse.
- R9: A cancel sets the remaining count to zero. The character that was running never produces a done pulse, and the next start begins a full new frame.
- R10: A configuration change takes effect from the next start. A character already counting completes with the length it was loaded with.
- R11: After reset, both done outputs are low and both channels are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| parity_en | input | 1 | Parity bit present in the frame |
| rx_len | input | 2 | Receive character length code |
| tx_len | input | 2 | Transmit character length code |
| stop_mode | input | 2 | Stop-bit / framing code |
| clk_mult | input | 2 | Clock multiplier code |
| tx_byte | input | 8 | Byte being transmitted, for length code 0 |
| tx_start | input | 1 | Begin a transmit character |
| tx_cancel | input | 1 | Abandon the transmit character |
| tx_clk_in | input | 1 | External transmit serial clock |
| tx_done | output | 1 | Transmit character complete pulse |
| rx_start | input | 1 | Begin a receive character |
| rx_cancel | input | 1 | Abandon the receive character |
| rx_clk_in | input | 1 | External receive serial clock |
| rx_done | output | 1 | Receive character complete pulse |

## Verification
The registered frame length follows a configuration change one clock later, so the bench waits two cycles after setting the fields before it issues a start. A level change on a clock input passes through two synchronizer stages and one history register before the counter acts on it, and done is high during the following cycle. A done pulse is therefore due within four cycles of the change. The bench makes each change on a falling system-clock edge, waits four cycles, and counts done pulses in a monitor. Each frame is then checked as no pulse after the expected count minus one, and exactly one pulse after the final change.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int unsigned PARITY_HALF   = 2;
  localparam int unsigned MAX_CHAR_HALF = 16;
  localparam int unsigned MAX_STOP_HALF = 6;
  localparam int unsigned MAX_SHIFT     = 6;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned HALF_W        = $clog2(PARITY_HALF + MAX_CHAR_HALF + MAX_STOP_HALF + 1);
  localparam int unsigned MAX_TOTAL     = (PARITY_HALF + MAX_CHAR_HALF + MAX_STOP_HALF) << MAX_SHIFT;
  localparam int unsigned CNT_W         = $clog2(MAX_TOTAL + 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic       parity_en;
    logic [1:0] len;
    logic [1:0] stop;
    logic [1:0] mult;
  } frame_cfg_t;

  // data bits implied by the leading pattern of a transmit byte
  function automatic logic [2:0] lead_bits(input logic [BYTE_W-1:0] b);
    logic [2:0] n;
    casez (b)
      8'b1111_000?: n = 3'd1;
      8'b1110_000?: n = 3'd2;
      8'b1100_00??: n = 3'd3;
      8'b1000_0???: n = 3'd4;
      default:      n = 3'd5;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/frame_len_calc.sv
module frame_len_calc
  import cft_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_cfg_t        cfg,
  input  logic [BYTE_W-1:0] data_byte,
  output cnt_t              total_q
);
  half_t char_half;
  half_t half_sum;
  cnt_t  scaled;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        unique case (cfg.len)
          2'd0: char_half = half_t'({lead_bits(data_byte), 1'b0});
          2'd1: char_half = half_t'(14);
          2'd2: char_half = half_t'(12);
          default: char_half = half_t'(16);
        endcase
      end
    end else begin : g_rx
      logic unused_byte;
      assign unused_byte = ^data_byte;
      always_comb begin
        unique case (cfg.len)
          2'd0: char_half = half_t'(10);
          2'd1: char_half = half_t'(14);
          2'd2: char_half = half_t'(12);
          default: char_half = half_t'(16);
        endcase
      end
    end
  endgenerate

  always_comb begin
    half_sum = char_half + (cfg.parity_en ? half_t'(PARITY_HALF) : half_t'(0));
    unique case (cfg.stop)
      2'd0: half_sum = half_sum;
      2'd1: half_sum = half_sum + half_t'(4);
      2'd2: half_sum = half_sum + half_t'(5);
      default: half_sum = half_sum + half_t'(6);
    endcase
    unique case (cfg.mult)
      2'd0: scaled = cnt_t'(half_sum);
      2'd1: scaled = cnt_t'(half_sum) << 4;
      2'd2: scaled = cnt_t'(half_sum) << 5;
      default: scaled = cnt_t'(half_sum) << MAX_SHIFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) total_q <= '0;
    else     total_q <= scaled;
  end

  // R5
  frame_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.stop != 2'd0) |=> (total_q != '0));
endmodule

// File: rtl/clk_level_detect.sv
module clk_level_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_clk,
  output logic lvl_change
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_clk};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_change = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/half_bit_counter.sv
module half_bit_counter
  import cft_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  input  logic lvl_change,
  input  cnt_t total,
  output logic done_q
);
  cnt_t remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cancel) begin
        remain_q <= '0;
      end else if (remain_q == '0) begin
        if (start) remain_q <= total;
      end else if (lvl_change) begin
        remain_q <= remain_q - cnt_t'(1);
        if (remain_q == cnt_t'(1)) done_q <= 1'b1;
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_change && remain_q != '0 && !cancel) |=> (remain_q == cnt_t'($past(remain_q) - cnt_t'(1))));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && remain_q != '0 && !cancel && !lvl_change) |=> $stable(remain_q));
  // R9
  cancel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> (!done_q && remain_q == '0));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (remain_q == '0) |=> !done_q);
endmodule

// File: rtl/frame_channel.sv
module frame_channel
  import cft_pkg::*;
#(
  parameter bit          IS_TX       = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_cfg_t        cfg,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              start,
  input  logic              cancel,
  input  logic              raw_clk,
  output logic              done
);
  cnt_t total;
  logic lvl_change;

  frame_len_calc #(.IS_TX(IS_TX)) calc_i (
    .clk(clk), .rst(rst), .cfg(cfg), .data_byte(data_byte), .total_q(total)
  );

  clk_level_detect #(.STAGES(SYNC_STAGES)) det_i (
    .clk(clk), .rst(rst), .raw_clk(raw_clk), .lvl_change(lvl_change)
  );

  half_bit_counter cnt_i (
    .clk(clk), .rst(rst), .start(start), .cancel(cancel),
    .lvl_change(lvl_change), .total(total), .done_q(done)
  );
endmodule

// File: rtl/char_frame_timer.sv
module char_frame_timer
  import cft_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              parity_en,
  input  logic [1:0]        rx_len,
  input  logic [1:0]        tx_len,
  input  logic [1:0]        stop_mode,
  input  logic [1:0]        clk_mult,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_start,
  input  logic              tx_cancel,
  input  logic              tx_clk_in,
  output logic              tx_done,
  input  logic              rx_start,
  input  logic              rx_cancel,
  input  logic              rx_clk_in,
  output logic              rx_done
);
  frame_cfg_t tx_cfg, rx_cfg;

  assign tx_cfg = '{parity_en: parity_en, len: tx_len, stop: stop_mode, mult: clk_mult};
  assign rx_cfg = '{parity_en: parity_en, len: rx_len, stop: stop_mode, mult: clk_mult};

  frame_channel #(.IS_TX(1'b1), .SYNC_STAGES(SYNC_STAGES)) tx_ch_i (
    .clk(clk), .rst(rst), .cfg(tx_cfg), .data_byte(tx_byte),
    .start(tx_start), .cancel(tx_cancel), .raw_clk(tx_clk_in), .done(tx_done)
  );

  frame_channel #(.IS_TX(1'b0), .SYNC_STAGES(SYNC_STAGES)) rx_ch_i (
    .clk(clk), .rst(rst), .cfg(rx_cfg), .data_byte(tx_byte),
    .start(rx_start), .cancel(rx_cancel), .raw_clk(rx_clk_in), .done(rx_done)
  );

  // R11
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (!tx_done && !rx_done));
endmodule

// File: tb/char_frame_timer_tb_top.sv
module char_frame_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic parity_en = 1'b0;
  logic [1:0] rx_len = 2'd0, tx_len = 2'd0, stop_mode = 2'd0, clk_mult = 2'd0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_start = 1'b0, tx_cancel = 1'b0, tx_clk_in = 1'b0, tx_done;
  logic rx_start = 1'b0, rx_cancel = 1'b0, rx_clk_in = 1'b0, rx_done;

  always #10 clk = ~clk;

  char_frame_timer dut_i (
    .clk(clk), .rst(rst), .parity_en(parity_en), .rx_len(rx_len), .tx_len(tx_len),
    .stop_mode(stop_mode), .clk_mult(clk_mult), .tx_byte(tx_byte),
    .tx_start(tx_start), .tx_cancel(tx_cancel), .tx_clk_in(tx_clk_in), .tx_done(tx_done),
    .rx_start(rx_start), .rx_cancel(rx_cancel), .rx_clk_in(rx_clk_in), .rx_done(rx_done)
  );

  typedef struct packed {
    logic       par;
    logic [1:0] rxl;
    logic [1:0] txl;
    logic [1:0] stp;
    logic [1:0] mul;
    logic [7:0] byt;
    logic [11:0] etx;
    logic [11:0] erx;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 8'h00, 12'd18,   12'd14},
    '{1'b1, 2'd1, 2'd2, 2'd2, 2'd0, 8'h00, 12'd19,   12'd21},
    '{1'b0, 2'd2, 2'd3, 2'd3, 2'd0, 8'h00, 12'd22,   12'd18},
    '{1'b1, 2'd3, 2'd0, 2'd0, 2'd0, 8'hF0, 12'd4,    12'd18},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'hE1, 12'd8,    12'd14},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'hC3, 12'd10,   12'd14},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'h87, 12'd12,   12'd14},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'h1F, 12'd14,   12'd14},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'h55, 12'd14,   12'd14},
    '{1'b0, 2'd0, 2'd1, 2'd1, 2'd1, 8'h00, 12'd288,  12'd224},
    '{1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 8'hF1, 12'd64,   12'd320},
    '{1'b1, 2'd3, 2'd3, 2'd3, 2'd3, 8'h00, 12'd1536, 12'd1536}
  };

  int n_chk = 0;
  int n_bad = 0;
  int tx_n = 0;
  int rx_n = 0;
  bit ended = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      tx_n <= 0;
      rx_n <= 0;
    end else begin
      if (tx_done) tx_n <= tx_n + 1;
      if (rx_done) rx_n <= rx_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic toggle(input bit is_tx);
    @(negedge clk);
    if (is_tx) tx_clk_in = ~tx_clk_in;
    else       rx_clk_in = ~rx_clk_in;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start(input bit is_tx);
    @(negedge clk);
    if (is_tx) tx_start = 1'b1; else rx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    rx_start = 1'b0;
  endtask

  task automatic pulse_cancel(input bit is_tx);
    @(negedge clk);
    if (is_tx) tx_cancel = 1'b1; else rx_cancel = 1'b1;
    @(negedge clk);
    tx_cancel = 1'b0;
    rx_cancel = 1'b0;
  endtask

  task automatic set_cfg(input vec_t v);
    @(negedge clk);
    parity_en = v.par;
    rx_len    = v.rxl;
    tx_len    = v.txl;
    stop_mode = v.stp;
    clk_mult  = v.mul;
    tx_byte   = v.byt;
    repeat (2) @(negedge clk);
  endtask

  // toggles exp-1 times (no pulse), then once more (one pulse), other channel unchanged
  task automatic run_frame(input bit is_tx, input int exp, input string req);
    int own0, oth0;
    own0 = is_tx ? tx_n : rx_n;
    oth0 = is_tx ? rx_n : tx_n;
    for (int i = 0; i < exp - 1; i++) toggle(is_tx);
    chk({req, " early"}, is_tx ? tx_n : rx_n, own0);
    toggle(is_tx);
    chk({req, " done"}, is_tx ? tx_n : rx_n, own0 + 1);
    chk("R7 other channel", is_tx ? rx_n : tx_n, oth0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 tx_done in reset", int'(tx_done), 0);
    chk("R11 rx_done in reset", int'(rx_done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 tx_done after reset", int'(tx_done), 0);
    // R8 idle: clock changes without a start do nothing
    for (int i = 0; i < 6; i++) begin
      toggle(1'b1);
      toggle(1'b0);
    end
    chk("R8 idle tx", tx_n, 0);
    chk("R8 idle rx", rx_n, 0);

    // table: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      set_cfg(VECS[k]);
      pulse_start(1'b1);
      run_frame(1'b1, int'(VECS[k].etx), $sformatf("R3/R4/R1/R5/R6 tx vec %0d", k));
      pulse_start(1'b0);
      run_frame(1'b0, int'(VECS[k].erx), $sformatf("R2/R1/R5/R6 rx vec %0d", k));
    end

    // R8 start while busy ignored
    set_cfg(VECS[0]);
    begin
      int b0;
      b0 = tx_n;
      pulse_start(1'b1);
      for (int i = 0; i < 5; i++) toggle(1'b1);
      pulse_start(1'b1);
      for (int i = 0; i < 12; i++) toggle(1'b1);
      chk("R8 busy restart early", tx_n, b0);
      toggle(1'b1);
      chk("R8 busy restart done at 18", tx_n, b0 + 1);
    end

    // R9 cancel
    begin
      int c0;
      c0 = rx_n;
      pulse_start(1'b0);
      for (int i = 0; i < 5; i++) toggle(1'b0);
      pulse_cancel(1'b0);
      for (int i = 0; i < 20; i++) toggle(1'b0);
      chk("R9 cancelled no done", rx_n, c0);
      pulse_start(1'b0);
      run_frame(1'b0, 14, "R9 fresh frame after cancel");
    end

    // R10 config change mid-frame
    begin
      int d0;
      vec_t v;
      d0 = tx_n;
      pulse_start(1'b1);
      for (int i = 0; i < 3; i++) toggle(1'b1);
      v = VECS[0];
      v.stp = 2'd3;
      set_cfg(v);
      for (int i = 0; i < 14; i++) toggle(1'b1);
      chk("R10 old length early", tx_n, d0);
      toggle(1'b1);
      chk("R10 old length done", tx_n, d0 + 1);
      pulse_start(1'b1);
      run_frame(1'b1, 20, "R10 new length");
    end

    finish_run();
  end
endmodule